// File: doc/BRIEF.md
# Raster Position Timer with Interrupt Event

This block keeps a horizontal and a vertical position counter for a coprocessor that runs beside a video system. It is not stepped on every clock. Whenever an update strobe arrives, the horizontal counter moves forward by the number of master cycles that have passed since the last update. When the horizontal counter passes the end of a line it wraps, and the vertical counter moves on by one line. Two geometries are available. In the linear geometry a line is 2048 cycles long and a frame has 512 lines. In the raster geometry the line length and the number of lines per frame come from inputs. The usual values are 1364 cycles per line and 262 lines per frame.

Software programs a horizontal dot position and a vertical line position, and either or both comparisons can be enabled. The horizontal counter jumps by several cycles per update, so it may never hold the exact compare value. For that reason a horizontal match means that the counter crossed the compare point during the update. A vertical match means that the new line number equals the programmed line. An event is raised only when the combined match goes from false to true between two updates. Each event sets a sticky status flag. If the timer interrupt is unmasked, the event also makes an interrupt pending. The interrupt arbiter acknowledges the pending interrupt, and software clears the status flag.

Top module: `hv_irq_timer`

## Requirements
- R1: After reset, both counters are zero, the match history is false, and timer_event, timer_status and irq_pending are low.
- R2: In the cycle after a clock edge with upd_valid high, h_count has increased by upd_cycles, reduced by the line length when it wraps. With upd_valid low, neither counter changes.
- R3: With linear_mode at 1, the line length is 2048 and the frame has 512 lines. A horizontal wrap takes the vertical counter from 511 to 0.
- R4: With linear_mode at 0, the horizontal counter wraps when it reaches line_len, and the vertical counter wraps to 0 when it reaches frame_lines.
- R5: The horizontal match holds when prev < P <= cur, where P = h_pos * DOT_CYCLES (default 4), cur is the new horizontal value, and prev is the old value. On a wrap, prev has the line length subtracted, so prev may be negative.
- R6: The vertical match holds when the vertical counter after the update equals v_pos.
- R7: With h_en alone, the horizontal match decides the condition. With v_en alone, the vertical match decides it. With both set, both matches must hold. With neither set, no event occurs.
- R8: An event occurs only on an update where the condition is true and was false on the previous update. Updates in which the condition stays true produce no further events.
- R9: An event shows as a one-cycle pulse on timer_event in the cycle after the update edge. In that same cycle timer_status is set, and irq_pending is set if irq_enable was 1 at the update edge.
- R10: irq_ack clears irq_pending and status_clr clears timer_status. If an event sets a flag in the same cycle that the flag is cleared, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update strobe |
| upd_cycles | input | CW (8) | Master cycles elapsed since the last update |
| linear_mode | input | 1 | 1: linear geometry of 2048 x 512; 0: raster geometry |
| h_en | input | 1 | Enable horizontal match |
| v_en | input | 1 | Enable vertical match |
| h_pos | input | PW (9) | Horizontal compare position, in dots |
| v_pos | input | VW (9) | Vertical compare line |
| line_len | input | HW (11) | Raster line length in cycles |
| frame_lines | input | VW (9) | Raster lines per frame |
| irq_enable | input | 1 | Timer interrupt unmask |
| irq_ack | input | 1 | Clear irq_pending |
| status_clr | input | 1 | Clear timer_status |
| h_count | output | HW (11) | Horizontal counter |
| v_count | output | VW (9) | Vertical counter |
| timer_event | output | 1 | One-cycle event pulse |
| timer_status | output | 1 | Sticky event flag |
| irq_pending | output | 1 | Pending timer interrupt |

## Verification
Two things can happen in the same cycle: an event sets timer_status and irq_pending, and irq_ack and status_clr clear those same flags. To provoke the clash, the bench uses a short raster line so that events come every few updates, and it holds both clear inputs high on every update. Every cycle is judged against a reference model in which a set beats a clear. A design that lets the clear win in that cycle shows a mismatch in the exact cycle of the event.

// File: rtl/hv_irq_timer.sv
module hv_irq_timer #(
  parameter int HW         = 11,
  parameter int VW         = 9,
  parameter int CW         = 8,
  parameter int PW         = 9,
  parameter int DOT_CYCLES = 4,
  parameter int LIN_LINE   = 2048,
  parameter int LIN_FRAME  = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_valid,
  input  logic [CW-1:0] upd_cycles,
  input  logic          linear_mode,
  input  logic          h_en,
  input  logic          v_en,
  input  logic [PW-1:0] h_pos,
  input  logic [VW-1:0] v_pos,
  input  logic [HW-1:0] line_len,
  input  logic [VW-1:0] frame_lines,
  input  logic          irq_enable,
  input  logic          irq_ack,
  input  logic          status_clr,
  output logic [HW-1:0] h_count,
  output logic [VW-1:0] v_count,
  output logic          timer_event,
  output logic          timer_status,
  output logic          irq_pending
);
  localparam int SW = HW + PW + 4;

  logic [HW-1:0] h_q;
  logic [VW-1:0] v_q;
  logic          last_q, ev_q, st_q, pd_q;

  logic signed [SW-1:0] h_lim, h_sum, h_cur, h_prv, cmp_pt;
  logic [VW:0]          v_lim, v_inc;
  logic [VW-1:0]        v_nxt;
  logic                 wrap, h_hit, v_hit, cond, fire;

  assign h_lim  = linear_mode ? SW'(LIN_LINE) : SW'(line_len);
  assign v_lim  = linear_mode ? (VW+1)'(LIN_FRAME) : (VW+1)'(frame_lines);
  assign h_sum  = SW'(h_q) + SW'(upd_cycles);
  assign wrap   = h_sum >= h_lim;
  assign h_cur  = wrap ? h_sum - h_lim : h_sum;
  assign h_prv  = wrap ? SW'(h_q) - h_lim : SW'(h_q);
  assign v_inc  = (VW+1)'(v_q) + (VW+1)'(1);
  assign v_nxt  = !wrap ? v_q : (v_inc >= v_lim ? '0 : v_inc[VW-1:0]);
  assign cmp_pt = SW'(h_pos) * SW'(DOT_CYCLES);

  assign h_hit = (h_prv < cmp_pt) && (h_cur >= cmp_pt);
  assign v_hit = v_nxt == v_pos;
  assign cond  = (h_en || v_en) && (h_hit || !h_en) && (v_hit || !v_en);
  assign fire  = upd_valid && cond && !last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q    <= '0;
      v_q    <= '0;
      last_q <= 1'b0;
      ev_q   <= 1'b0;
      st_q   <= 1'b0;
      pd_q   <= 1'b0;
    end else begin
      ev_q <= fire;
      if (upd_valid) begin
        h_q    <= h_cur[HW-1:0];
        v_q    <= v_nxt;
        last_q <= cond;
      end
      if (fire)            st_q <= 1'b1;
      else if (status_clr) st_q <= 1'b0;
      if (fire && irq_enable) pd_q <= 1'b1;
      else if (irq_ack)       pd_q <= 1'b0;
    end
  end

  assign h_count      = h_q;
  assign v_count      = v_q;
  assign timer_event  = ev_q;
  assign timer_status = st_q;
  assign irq_pending  = pd_q;
endmodule

module hv_irq_timer_chk #(
  parameter int HW = 11,
  parameter int VW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          upd_valid,
  input logic          h_en,
  input logic          v_en,
  input logic          irq_enable,
  input logic [HW-1:0] h_count,
  input logic [VW-1:0] v_count,
  input logic          timer_event,
  input logic          timer_status,
  input logic          irq_pending
);
  assert_status_follows_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_event |-> timer_status);

  assert_pending_follows_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_event && $past(irq_enable)) |-> irq_pending);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timer_event |=> !timer_event);

  assert_hold_without_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ($stable(h_count) && $stable(v_count)));

  assert_no_event_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !h_en && !v_en) |=> !timer_event);

  assert_event_needs_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> !timer_event);
endmodule

bind hv_irq_timer hv_irq_timer_chk #(.HW(HW), .VW(VW)) chk_i (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .h_en(h_en), .v_en(v_en),
  .irq_enable(irq_enable), .h_count(h_count), .v_count(v_count),
  .timer_event(timer_event), .timer_status(timer_status), .irq_pending(irq_pending)
);

// File: tb/hv_irq_timer_tb_top.sv
`timescale 1ns/1ps
module hv_irq_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic [7:0] upd_cycles = '0;
  logic linear_mode = 1'b0, h_en = 1'b0, v_en = 1'b0;
  logic [8:0] h_pos = '0, v_pos = '0;
  logic [10:0] line_len = 11'd1364;
  logic [8:0] frame_lines = 9'd262;
  logic irq_enable = 1'b0, irq_ack = 1'b0, status_clr = 1'b0;
  logic [10:0] h_count;
  logic [8:0] v_count;
  logic timer_event, timer_status, irq_pending;

  always #2 clk = ~clk;

  hv_irq_timer dut_i (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_cycles(upd_cycles),
    .linear_mode(linear_mode), .h_en(h_en), .v_en(v_en), .h_pos(h_pos),
    .v_pos(v_pos), .line_len(line_len), .frame_lines(frame_lines),
    .irq_enable(irq_enable), .irq_ack(irq_ack), .status_clr(status_clr),
    .h_count(h_count), .v_count(v_count), .timer_event(timer_event),
    .timer_status(timer_status), .irq_pending(irq_pending));

  typedef struct packed {
    logic [15:0] h;
    logic [15:0] v;
    logic ev;
    logic st;
    logic pd;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int n_cmp = 0, n_bad = 0, n_events = 0;
  bit done = 1'b0;

  int  mh = 0, mv = 0;
  bit  mlast = 0, mst = 0, mpd = 0;

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic step(input bit vld, input int cyc, input bit ack, input bit sclr, input string tag);
    int hl, vl, hs, hp, nv, cmp;
    bit hh, vh, cond, fire;
    exp_t e;
    @(negedge clk);
    upd_valid  = vld;
    upd_cycles = 8'(cyc);
    irq_ack    = ack;
    status_clr = sclr;
    fire = 1'b0;
    if (vld) begin
      hl = linear_mode ? 2048 : int'(line_len);
      vl = linear_mode ? 512 : int'(frame_lines);
      hs = mh + cyc;
      hp = mh;
      nv = mv;
      if (hs >= hl) begin
        hs -= hl;
        hp -= hl;
        nv = mv + 1;
        if (nv >= vl) nv = 0;
      end
      cmp  = int'(h_pos) * 4;
      hh   = (hp < cmp) && (hs >= cmp);
      vh   = nv == int'(v_pos);
      cond = (h_en || v_en) && (hh || !h_en) && (vh || !v_en);
      fire = cond && !mlast;
      mlast = cond;
      mh = hs;
      mv = nv;
    end
    if (fire) mst = 1'b1; else if (sclr) mst = 1'b0;
    if (fire && irq_enable) mpd = 1'b1; else if (ack) mpd = 1'b0;
    if (fire) n_events++;
    e.h = 16'(mh); e.v = 16'(mv); e.ev = fire; e.st = mst; e.pd = mpd;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if ({5'd0, h_count} !== e.h || {7'd0, v_count} !== e.v || timer_event !== e.ev ||
            timer_status !== e.st || irq_pending !== e.pd) begin
          n_bad++;
          $display("FAIL %s: got h=%0d v=%0d ev=%0b st=%0b pd=%0b, expected h=%0d v=%0d ev=%0b st=%0b pd=%0b",
                   t, h_count, v_count, timer_event, timer_status, irq_pending,
                   e.h, e.v, e.ev, e.st, e.pd);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_up();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    step(0, 0, 0, 0, "R1 reset state");

    // R2: advance and hold
    for (int i = 0; i < 6; i++) step(1, 17 + i, 0, 0, "R2 advance");
    for (int i = 0; i < 3; i++) step(0, 99, 0, 0, "R2 hold without update");

    // R3: linear geometry, full frame wrap, no enables
    linear_mode = 1'b1;
    for (int i = 0; i < 4200; i++) step(1, 255, 0, 0, "R3 linear wrap");

    // R4 + R5: raster geometry, horizontal crossing
    linear_mode = 1'b0; h_en = 1'b1; h_pos = 9'd100; irq_enable = 1'b1;
    for (int i = 0; i < 420; i++) step(1, 13, 0, 0, "R5 horizontal crossing");
    // R5: compare point at 0 is crossed right after each wrap
    h_pos = 9'd0;
    for (int i = 0; i < 120; i++) step(1, 200, 1, 1, "R5 crossing at wrap");

    // R6 + R8 + R4: vertical match only, one event per frame
    h_en = 1'b0; v_en = 1'b1; v_pos = 9'd2;
    for (int i = 0; i < 3800; i++) step(1, 97, 0, 0, "R6 R8 R4 vertical match");

    // R7: both enabled
    h_en = 1'b1; h_pos = 9'd50; v_pos = 9'd1;
    for (int i = 0; i < 3800; i++) step(1, 97, 1, 1, "R7 both conditions");
    // R7: none enabled
    h_en = 1'b0; v_en = 1'b0;
    for (int i = 0; i < 300; i++) step(1, 61, 0, 0, "R7 no enables");

    // R9: masked interrupt sets status only
    step(0, 0, 1, 1, "R10 clear flags");
    h_en = 1'b1; irq_enable = 1'b0; h_pos = 9'd5; line_len = 11'd100;
    for (int i = 0; i < 60; i++) step(1, 30, 0, 0, "R9 masked event");

    // R10: clears every update; events collide with clears
    irq_enable = 1'b1;
    for (int i = 0; i < 200; i++) step(1, 30, 1, 1, "R10 set beats clear");
    for (int i = 0; i < 3; i++) step(0, 0, 1, 1, "R10 idle clear");

    @(negedge clk);
    @(negedge clk);
    if (n_events == 0) begin
      n_bad++;
      $display("FAIL R9: got 0 events in the run, expected some");
    end
    n_cmp++;
    finish_up();
  end
endmodule